// File: doc/BRIEF.md
# Configuration-Phase LED Status Multiplexer

This block owns a bank of eight active-high indicator LEDs that sit next to a target FPGA on a board. What the LEDs mean depends on where the target is in its configuration sequence. The block follows the target's program, INIT and DONE lines to track three phases: idle, loading and running.

While the target is idle, seven of the LEDs form a one-hot display of the 3-bit configuration-mode selector. The eighth LED shows whether the clock-doubling loop has locked. While the target is loading, the block releases all eight LED pins to high impedance. It does this by dropping their output enables, so the target can use those pins during configuration. Once the target is running, the LEDs simply echo eight user data bits.

The block also turns two active-low pushbuttons into pull-down requests toward the target. Each button first passes through a two-flop synchronizer. The program button pulls the target's program line low. The reset button pulls the target's INIT line low, but only once configuration has finished and INIT has become an ordinary user pin. Mode 7 is the passive mode: the idle display still runs, but neither button request is ever issued.

Top module: `cfg_led_mux`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, the block is in the idle phase: `led_oe` is all ones, and neither `tgt_prog_pull` nor `tgt_init_pull` is asserted.
- R2: In the idle phase, `led_o[n]` for n = 0 to 6 is 1 exactly when `mode_sel` equals n. With `mode_sel` = 7, bits 0 to 6 are all 0. `led_oe` is all ones.
- R3: In the idle phase, `led_o[7]` equals `clk_lock`.
- R4: In the loading phase, `led_oe` is all zeros (every LED pin is high impedance) and `led_o` is all zeros. `led_oe` is always either all ones or all zeros.
- R5: In the running phase, `led_o` equals `user_data` bit for bit, and `led_oe` is all ones.
- R6: Phase changes take one clock edge. Idle becomes loading when `tgt_prog_n` and `tgt_init` are both high. Loading becomes running when `tgt_done` is high. The running phase holds whatever `tgt_init` and `tgt_done` do afterwards. While `tgt_prog_n` is low, INIT high does not leave idle.
- R7: A low `tgt_prog_n` sampled at a clock edge puts the block in the idle phase after that edge, whatever the phase was.
- R8: With `mode_sel` not 7, `tgt_prog_pull` goes high at the second rising edge after `prog_btn_n` goes low, and goes low again at the second rising edge after the button is released.
- R9: `tgt_init_pull` is high only in the running phase, with `mode_sel` not 7, and starting at the second rising edge after `rst_btn_n` goes low. In the idle and loading phases the reset button has no effect.
- R10: When `mode_sel` equals 7, `tgt_prog_pull` and `tgt_init_pull` are both low in the same cycle, whatever the button state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Configuration-mode selector |
| clk_lock | input | 1 | Clock-doubling loop lock flag |
| user_data | input | 8 | User data shown in the running phase |
| prog_btn_n | input | 1 | Program pushbutton, active low, asynchronous |
| rst_btn_n | input | 1 | Reset pushbutton, active low, asynchronous |
| tgt_prog_n | input | 1 | Observed level of the target's program line |
| tgt_init | input | 1 | Observed level of the target's INIT line |
| tgt_done | input | 1 | Observed level of the target's DONE line |
| led_o | output | 8 | LED data |
| led_oe | output | 8 | LED output enables; 0 means high impedance |
| tgt_prog_pull | output | 1 | 1 pulls the target's program line low |
| tgt_init_pull | output | 1 | 1 pulls the target's INIT line low |

## Verification
Several rules are checked on every cycle by assertions. Mode 7 must block both pull requests. A low program line must force the idle display after the next edge. The LED enables must never split into a mix of driven and released pins. The INIT pull must never appear while the pins are released. The two-edge latency of the program button is also checked on every cycle.

Other behaviour only the bench's scenarios can show. These include the exact one-hot pattern for every mode value and the echo of random user data in the running phase. They also include the running phase holding while DONE and INIT toggle, and INIT high being ignored while the program line is held low. The exact two-edge delay of the reset-button pull in the running phase, and its absence in the other phases, also come from the bench.

// File: rtl/cfg_led_pkg.sv
package cfg_led_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOADING = 2'd1,
        PH_RUNNING = 2'd2
    } cfg_phase_e;

    // Observed levels of the target's configuration lines
    typedef struct packed {
        logic prog_n;
        logic init;
        logic done;
    } tgt_lines_s;

    // Synchronized pushbutton levels (active low)
    typedef struct packed {
        logic prog_n;
        logic rst_n;
    } btn_levels_s;

    localparam int unsigned BTN_COUNT = $bits(btn_levels_s);

    function automatic logic leds_driven(cfg_phase_e ph);
        return ph != PH_LOADING;
    endfunction

endpackage

// File: rtl/cfg_btn_sync.sv
module cfg_btn_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter int unsigned STAGES    = 2,
    parameter logic        IDLE_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= {WIDTH{IDLE_LEVEL}};
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
    import cfg_led_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tgt_lines_s lines,
    output cfg_phase_e phase
);

    cfg_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (!lines.prog_n) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:    if (lines.init) phase_d = PH_LOADING;
                PH_LOADING: if (lines.done) phase_d = PH_RUNNING;
                PH_RUNNING: phase_d = PH_RUNNING;
                default:    phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

endmodule

// File: rtl/cfg_led_sel.sv
module cfg_led_sel
    import cfg_led_pkg::*;
#(
    parameter int unsigned LED_W  = 8,
    parameter int unsigned MODE_W = 3
) (
    input  cfg_phase_e        phase,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              clk_lock,
    input  logic [LED_W-1:0]  user_data,
    output logic [LED_W-1:0]  led_o,
    output logic [LED_W-1:0]  led_oe
);

    localparam int unsigned STATUS_W = LED_W - 1;

    logic [LED_W-1:0] idle_view;

    // One status LED per selectable mode index, the top LED for lock
    for (genvar i = 0; i < STATUS_W; i++) begin : g_status
        assign idle_view[i] = (mode_sel == MODE_W'(i));
    end
    assign idle_view[LED_W-1] = clk_lock;

    for (genvar i = 0; i < LED_W; i++) begin : g_pin
        always_comb begin
            unique case (phase)
                PH_IDLE:    led_o[i] = idle_view[i];
                PH_RUNNING: led_o[i] = user_data[i];
                default:    led_o[i] = 1'b0;
            endcase
            led_oe[i] = leds_driven(phase);
        end
    end

endmodule

// File: rtl/cfg_led_mux.sv
module cfg_led_mux
    import cfg_led_pkg::*;
#(
    parameter int unsigned LED_W        = 8,
    parameter int unsigned MODE_W       = 3,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned PASSIVE_MODE = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              clk_lock,
    input  logic [LED_W-1:0]  user_data,
    input  logic              prog_btn_n,
    input  logic              rst_btn_n,
    input  logic              tgt_prog_n,
    input  logic              tgt_init,
    input  logic              tgt_done,
    output logic [LED_W-1:0]  led_o,
    output logic [LED_W-1:0]  led_oe,
    output logic              tgt_prog_pull,
    output logic              tgt_init_pull
);

    btn_levels_s btn_raw, btn_q;
    tgt_lines_s  lines;
    cfg_phase_e  phase;
    logic        buttons_live;

    assign btn_raw = '{prog_n: prog_btn_n, rst_n: rst_btn_n};
    assign lines   = '{prog_n: tgt_prog_n, init: tgt_init, done: tgt_done};

    cfg_btn_sync #(
        .WIDTH     (BTN_COUNT),
        .STAGES    (SYNC_STAGES),
        .IDLE_LEVEL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(btn_raw),
        .sync_out(btn_q)
    );

    cfg_phase_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .lines(lines),
        .phase(phase)
    );

    cfg_led_sel #(
        .LED_W (LED_W),
        .MODE_W(MODE_W)
    ) u_sel (
        .phase    (phase),
        .mode_sel (mode_sel),
        .clk_lock (clk_lock),
        .user_data(user_data),
        .led_o    (led_o),
        .led_oe   (led_oe)
    );

    assign buttons_live  = (mode_sel != MODE_W'(PASSIVE_MODE));
    assign tgt_prog_pull = buttons_live && !btn_q.prog_n;
    assign tgt_init_pull = buttons_live && (phase == PH_RUNNING) && !btn_q.rst_n;

endmodule

// File: rtl/cfg_led_mux_chk.sv
module cfg_led_mux_chk #(
    parameter int unsigned LED_W        = 8,
    parameter int unsigned MODE_W       = 3,
    parameter int unsigned PASSIVE_MODE = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_sel,
    input logic              prog_btn_n,
    input logic              tgt_prog_n,
    input logic [LED_W-1:0]  led_o,
    input logic [LED_W-1:0]  led_oe,
    input logic              tgt_prog_pull,
    input logic              tgt_init_pull
);

    logic [1:0]       since_rst;
    logic [LED_W-2:0] want_status;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always_comb begin
        want_status = '0;
        for (int i = 0; i < LED_W-1; i++) begin
            if (mode_sel == MODE_W'(i)) want_status[i] = 1'b1;
        end
    end

    p_passive_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == MODE_W'(PASSIVE_MODE)) |-> (!tgt_prog_pull && !tgt_init_pull));

    p_prog_forces_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !tgt_prog_n |=> ((led_oe == '1) && (led_o[LED_W-2:0] == want_status)));

    p_oe_uniform_r4: assert property (@(posedge clk) disable iff (rst)
        (led_oe == '0) || (led_oe == '1));

    p_init_pull_driven_r9: assert property (@(posedge clk) disable iff (rst)
        tgt_init_pull |-> (led_oe == '1));

    p_prog_btn_latency_r8: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) && !$past(prog_btn_n, 2)
         && (mode_sel != MODE_W'(PASSIVE_MODE))) |-> tgt_prog_pull);

endmodule

bind cfg_led_mux cfg_led_mux_chk #(
    .LED_W       (LED_W),
    .MODE_W      (MODE_W),
    .PASSIVE_MODE(PASSIVE_MODE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .prog_btn_n   (prog_btn_n),
    .tgt_prog_n   (tgt_prog_n),
    .led_o        (led_o),
    .led_oe       (led_oe),
    .tgt_prog_pull(tgt_prog_pull),
    .tgt_init_pull(tgt_init_pull)
);

// File: tb/cfg_led_mux_test.sv
module cfg_led_mux_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic       clk_lock = 1'b0;
    logic [7:0] user_data = 8'h00;
    logic       prog_btn_n = 1'b1;
    logic       rst_btn_n = 1'b1;
    logic       ext_prog_n = 1'b1;
    logic       tgt_init = 1'b0;
    logic       tgt_done = 1'b0;
    logic       tgt_prog_n;
    logic [7:0] led_o, led_oe;
    logic       tgt_prog_pull, tgt_init_pull;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    // Board model: program line is low if pulled by the block or by the bench
    assign tgt_prog_n = ext_prog_n & ~tgt_prog_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_led_mux uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .clk_lock(clk_lock),
        .user_data(user_data), .prog_btn_n(prog_btn_n), .rst_btn_n(rst_btn_n),
        .tgt_prog_n(tgt_prog_n), .tgt_init(tgt_init), .tgt_done(tgt_done),
        .led_o(led_o), .led_oe(led_oe),
        .tgt_prog_pull(tgt_prog_pull), .tgt_init_pull(tgt_init_pull)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [7:0] idle_pattern(logic [2:0] m, logic lk);
        logic [7:0] v = 8'h00;
        if (m < 3'd7) v[m] = 1'b1;
        v[7] = lk;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_idle(string req);
        check(req, {24'd0, led_o}, {24'd0, idle_pattern(mode_sel, clk_lock)});
        check(req, {24'd0, led_oe}, 32'hFF);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        repeat (3) tick();
        check("R1", {24'd0, led_oe}, 32'hFF);
        check("R1", {30'd0, tgt_prog_pull, tgt_init_pull}, 32'd0);
        rst = 1'b0;
        tick();
        check_idle("R1");
        check("R1", {30'd0, tgt_prog_pull, tgt_init_pull}, 32'd0);

        // R2 R3: random idle display, reset button has no effect (R9)
        for (int i = 0; i < 40; i++) begin
            mode_sel  = 3'($urandom_range(0, 6));
            clk_lock  = 1'($urandom);
            user_data = 8'($urandom);
            rst_btn_n = 1'($urandom);
            tick();
            check_idle("R2_R3");
            check("R9", {31'd0, tgt_init_pull}, 32'd0);
        end
        // every mode value including the passive one
        for (int m = 0; m < 8; m++) begin
            mode_sel = 3'(m);
            clk_lock = 1'(m);
            #1;
            check_idle("R2");
        end
        rst_btn_n = 1'b1;
        mode_sel  = 3'd1;
        tick(); tick();

        // R6: idle -> loading
        tgt_init = 1'b1;
        tick();
        check("R6", {24'd0, led_oe}, 32'h00);
        for (int i = 0; i < 30; i++) begin
            mode_sel  = 3'($urandom_range(0, 6));
            clk_lock  = 1'($urandom);
            user_data = 8'($urandom);
            rst_btn_n = 1'($urandom);
            tick();
            check("R4", {24'd0, led_oe}, 32'h00);
            check("R4", {24'd0, led_o}, 32'h00);
            check("R9", {31'd0, tgt_init_pull}, 32'd0);
        end
        rst_btn_n = 1'b1;
        tick(); tick();

        // R6: loading -> running, then hold while INIT/DONE move
        tgt_done = 1'b1;
        tick();
        check("R6", {24'd0, led_oe}, 32'hFF);
        for (int i = 0; i < 40; i++) begin
            mode_sel  = 3'($urandom);
            user_data = 8'($urandom);
            clk_lock  = 1'($urandom);
            tgt_done  = 1'($urandom);
            tgt_init  = 1'($urandom);
            tick();
            check("R5_R6", {24'd0, led_o}, {24'd0, user_data});
            check("R5", {24'd0, led_oe}, 32'hFF);
        end

        // R9: reset button in running phase, two-edge latency
        mode_sel  = 3'd2;
        rst_btn_n = 1'b0;
        tick();
        check("R9", {31'd0, tgt_init_pull}, 32'd0);
        tick();
        check("R9", {31'd0, tgt_init_pull}, 32'd1);
        // R10: passive mode blocks it immediately
        mode_sel = 3'd7;
        #1;
        check("R10", {31'd0, tgt_init_pull}, 32'd0);
        mode_sel  = 3'd2;
        rst_btn_n = 1'b1;
        tick(); tick();
        check("R9", {31'd0, tgt_init_pull}, 32'd0);

        // R8 R7: program button from running phase
        mode_sel = 3'd3;
        tgt_init = 1'b0;
        tgt_done = 1'b0;
        prog_btn_n = 1'b0;
        tick();
        check("R8", {31'd0, tgt_prog_pull}, 32'd0);
        check("R5", {24'd0, led_oe}, 32'hFF);
        tick();
        check("R8", {31'd0, tgt_prog_pull}, 32'd1);
        tick();
        check_idle("R7");
        prog_btn_n = 1'b1;
        tick();
        check("R8", {31'd0, tgt_prog_pull}, 32'd1);
        tick();
        check("R8", {31'd0, tgt_prog_pull}, 32'd0);
        tick();
        check_idle("R6");

        // R10: passive mode never pulls program, idle display still runs
        mode_sel = 3'd7;
        clk_lock = 1'b1;
        prog_btn_n = 1'b0;
        rst_btn_n  = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R10", {30'd0, tgt_prog_pull, tgt_init_pull}, 32'd0);
            check_idle("R10");
        end
        prog_btn_n = 1'b1;
        rst_btn_n  = 1'b1;
        mode_sel   = 3'd0;
        tick(); tick();

        // R7: external program low from loading phase; R6: INIT ignored while low
        tgt_init = 1'b1;
        tick();
        check("R6", {24'd0, led_oe}, 32'h00);
        ext_prog_n = 1'b0;
        tick();
        check_idle("R7");
        tick();
        check_idle("R6");
        ext_prog_n = 1'b1;
        tick();
        check("R6", {24'd0, led_oe}, 32'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule